// File: doc/BRIEF.md
# Full-Duplex Serial Peripheral Master with Queued Exchange

This block is a serial peripheral master that sits on a simple 32-bit register bus. Software sets up a control word, queues up to eight transmit words in a FIFO, and then sets an exchange bit. The core sends the whole queue out on the serial lines. Each word is 1 to 32 bits long. Every bit it shifts out is matched by a bit it samples in, and each completed received word goes into an eight-entry receive FIFO. Software reads that FIFO back one word per bus read.

The serial clock can run in any of the four polarity and phase combinations. Its rate is the bus clock divided by four times a power of two, where the power is set by a 3-bit code. One of several chip-select lines is chosen by an index field, and its active level can be set. A chip select either stays asserted across a whole burst or drops for a short gap between words. A level-sensitive interrupt combines the transmit-empty and receive-ready conditions, each under its own enable bit. A write of 1 to a dedicated offset clears the whole block back to its reset state.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, and after a bus write with data bit 0 set at offset 0x1C, the control register (0x08) reads 0, the status register (0x14) reads 0x01, every chip-select line sits at its inactive level, and the serial clock rests at the polarity held in control bit 4.
- R2: Words are shifted most-significant bit first. Only the low N bits of each transmit word are sent, where N is control bits 12:8 plus one, and each word gives exactly 2·N serial clock edges.
- R3: Each received word is right-aligned and zero-extended. A read at offset 0x00 returns the oldest received word and removes it. Status bit 3 is 1 exactly while the receive FIFO holds a word.
- R4: When idle, the serial clock rests at control bit 4. With control bit 5 clear, the input is sampled on the edge leading away from the idle level. With control bit 5 set, it is sampled on the edge returning to it. The output data is stable at each sampling edge.
- R5: The serial clock half-period is 2·2^n bus clocks, where n is control bits 18:16.
- R6: Setting control bit 2 starts a burst only while control bits 0 (enable) and 1 (master) are both 1. The burst sends every queued word. Bit 2 then clears itself once the transmit FIFO is empty and the last word has finished, and it reads back 0.
- R7: Control bits 25:24 select which chip-select line is driven, and control bit 7 set makes that line active-high. The line stays asserted for the whole burst. With control bit 6 set, it is released between words.
- R8: The transmit FIFO (write at offset 0x04) holds 8 words. A write while it is full is dropped. Status bit 0 is 1 while it is empty.
- R9: The receive FIFO holds 8 words. A word that completes while it is full is discarded, and status bit 7 is set. Bit 7 stays set until the soft reset.
- R10: The interrupt output is the OR of (interrupt-enable bit 0 AND transmit FIFO empty) and (interrupt-enable bit 3 AND receive FIFO non-empty), where the enables sit at offset 0x0C. It follows these conditions as a level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| irq | output | 1 | Level interrupt request |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | CS_LINES | Chip-select lines, one per target |

## Verification
A wrong edge counter or phase flag shows on the pins within one word. The word sampled by an external observer loses or reorders bits, and the received word read back differs from the looped-back data. A bad divider shows as a wrong half-period from the first two serial clock edges onward. A FIFO pointer or count error shows as a wrong word order, a missing word or a wrong status bit on the first read after a burst. A stuck exchange bit or stuck overflow flag shows on the next control or status read.

// File: rtl/spim_pkg.sv
package spim_pkg;
  // register offsets (software decodes these)
  localparam logic [4:0] OFF_RXD  = 5'h00;
  localparam logic [4:0] OFF_TXD  = 5'h04;
  localparam logic [4:0] OFF_CTL  = 5'h08;
  localparam logic [4:0] OFF_IEN  = 5'h0C;
  localparam logic [4:0] OFF_STA  = 5'h14;
  localparam logic [4:0] OFF_SRST = 5'h1C;

  // control field positions
  localparam int C_EN        = 0;
  localparam int C_MST       = 1;
  localparam int C_XCH       = 2;
  localparam int C_CPOL      = 4;
  localparam int C_CPHA      = 5;
  localparam int C_GAP       = 6;
  localparam int C_CSPOL     = 7;
  localparam int C_BITS_LSB  = 8;
  localparam int C_RATE_LSB  = 16;
  localparam int C_CSIDX_LSB = 24;

  // interrupt enable and status bit positions
  localparam int IE_TXE  = 0;
  localparam int IE_RXR  = 3;
  localparam int ST_TXE  = 0;
  localparam int ST_RXR  = 3;
  localparam int ST_OVF  = 7;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_HOLD  = 2'd2,
    ENG_GAP   = 2'd3
  } eng_state_e;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp_q];

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (push_ok) wp_n = (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop_ok)  rp_n = (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (push_ok && !pop_ok)      cnt_n = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_n = cnt_q - 1'b1;
    if (clr) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  // storage carries no reset; written only under its enable
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= din;
  end

  // R8 / R9: occupancy never passes the depth
  p_fifo_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R3: a pop from a non-empty FIFO always lowers occupancy unless a push lands
  p_pop_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push && !clr) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/spim_baud.sv
module spim_baud #(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int CNT_W = (1 << RATE_W) + 1;

  logic [CNT_W-1:0] cnt_q, cnt_n, half;

  // half serial period in bus clocks: 2 * 2^rate
  assign half = CNT_W'(2) << rate;
  assign tick = run && (cnt_q == half - CNT_W'(1));

  always_comb begin
    if (!run || tick) cnt_n = '0;
    else              cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R5: counter stays below the programmed half period
  p_cnt_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < half));
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RATE_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       go,
  input  logic                       tx_avail,
  input  logic [DATA_W-1:0]          tx_word,
  input  logic [$clog2(DATA_W)-1:0]  bits_m1,
  input  logic                       cpol,
  input  logic                       cpha,
  input  logic                       gap,
  input  logic [RATE_W-1:0]          rate,
  input  logic                       miso,
  output logic                       tx_pop,
  output logic                       rx_push,
  output logic [DATA_W-1:0]          rx_word,
  output logic                       mosi,
  output logic                       sclk,
  output logic                       cs_act,
  output logic                       busy
);
  localparam int BC_W = $clog2(DATA_W);
  localparam int EC_W = BC_W + 1;

  eng_state_e        st_q, st_n;
  logic [DATA_W-1:0] tx_q, tx_n, rx_q, rx_n;
  logic [EC_W-1:0]   e_q, e_n;
  logic              lvl_q, lvl_n, cs_q, cs_n;
  logic              tick, load, sample_edge;

  spim_baud #(.RATE_W(RATE_W)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .rate (rate),
    .tick (tick)
  );

  assign busy        = (st_q != ENG_IDLE);
  assign sample_edge = (e_q[0] == cpha);
  assign mosi        = cs_q & tx_q[DATA_W-1];
  assign sclk        = cpol ^ lvl_q;
  assign cs_act      = cs_q;
  assign rx_word     = rx_q;

  always_comb begin
    st_n    = st_q;
    tx_n    = tx_q;
    rx_n    = rx_q;
    e_n     = e_q;
    lvl_n   = lvl_q;
    cs_n    = cs_q;
    load    = 1'b0;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    unique case (st_q)
      ENG_IDLE: begin
        if (go && tx_avail) load = 1'b1;
      end
      ENG_SHIFT: begin
        if (tick) begin
          lvl_n = ~lvl_q;
          e_n   = e_q + 1'b1;
          if (sample_edge)         rx_n = {rx_q[DATA_W-2:0], miso};
          else if (e_q != '0)      tx_n = tx_q << 1;
          if (e_q == {bits_m1, 1'b1}) st_n = ENG_HOLD;
        end
      end
      ENG_HOLD: begin
        if (tick) begin
          rx_push = 1'b1;
          if (go && tx_avail) begin
            if (gap) begin
              cs_n = 1'b0;
              st_n = ENG_GAP;
            end else begin
              load = 1'b1;
            end
          end else begin
            cs_n = 1'b0;
            st_n = ENG_IDLE;
          end
        end
      end
      ENG_GAP: begin
        if (tick) begin
          if (go && tx_avail) load = 1'b1;
          else                st_n = ENG_IDLE;
        end
      end
      default: st_n = ENG_IDLE;
    endcase
    if (load) begin
      tx_pop = 1'b1;
      tx_n   = tx_word << (BC_W'(DATA_W - 1) - bits_m1);
      rx_n   = '0;
      lvl_n  = 1'b0;
      e_n    = '0;
      cs_n   = 1'b1;
      st_n   = ENG_SHIFT;
    end
    if (clr) begin
      st_n    = ENG_IDLE;
      tx_n    = '0;
      rx_n    = '0;
      e_n     = '0;
      lvl_n   = 1'b0;
      cs_n    = 1'b0;
      tx_pop  = 1'b0;
      rx_push = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      tx_q  <= '0;
      rx_q  <= '0;
      e_q   <= '0;
      lvl_q <= 1'b0;
      cs_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      tx_q  <= tx_n;
      rx_q  <= rx_n;
      e_q   <= e_n;
      lvl_q <= lvl_n;
      cs_q  <= cs_n;
    end
  end

  // R4: idle clock rests at the programmed polarity
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_IDLE) |-> (sclk == cpol));
  // R7: no chip select outside a burst
  p_cs_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_IDLE) |-> !cs_act);
  // R5: the clock level only moves after a divider tick
  p_edge_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> $past(tick));
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  parameter int CS_LINES = 4,
  parameter int RATE_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [4:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                irq,
  output logic                spi_sclk,
  output logic                spi_mosi,
  input  logic                spi_miso,
  output logic [CS_LINES-1:0] spi_cs
);
  localparam int BC_W  = $clog2(DATA_W);
  localparam int CSI_W = $clog2(CS_LINES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // bus decode
  logic wr_ctl, wr_ien, wr_txd, rd_rxd, srst;
  assign wr_ctl = bus_en && bus_we && (bus_addr == OFF_CTL);
  assign wr_ien = bus_en && bus_we && (bus_addr == OFF_IEN);
  assign wr_txd = bus_en && bus_we && (bus_addr == OFF_TXD);
  assign rd_rxd = bus_en && !bus_we && (bus_addr == OFF_RXD);
  assign srst   = bus_en && bus_we && (bus_addr == OFF_SRST) && bus_wdata[0];

  // control and enable state
  logic              en_q, en_n, mst_q, mst_n, xch_q, xch_n;
  logic              cpol_q, cpol_n, cpha_q, cpha_n, gap_q, gap_n, cspol_q, cspol_n;
  logic [BC_W-1:0]   bits_q, bits_n;
  logic [RATE_W-1:0] rate_q, rate_n;
  logic [CSI_W-1:0]  csidx_q, csidx_n;
  logic              ie_txe_q, ie_txe_n, ie_rxr_q, ie_rxr_n, ovf_q, ovf_n;

  // datapath links
  logic [DATA_W-1:0] tx_head, rx_word, rx_head;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic              tx_pop, rx_push, busy, cs_act, go;

  assign go = xch_q && en_q && mst_q;

  always_comb begin
    en_n     = en_q;
    mst_n    = mst_q;
    xch_n    = xch_q;
    cpol_n   = cpol_q;
    cpha_n   = cpha_q;
    gap_n    = gap_q;
    cspol_n  = cspol_q;
    bits_n   = bits_q;
    rate_n   = rate_q;
    csidx_n  = csidx_q;
    ie_txe_n = ie_txe_q;
    ie_rxr_n = ie_rxr_q;
    ovf_n    = ovf_q;
    if (xch_q && !busy && tx_empty) xch_n = 1'b0;
    if (wr_ctl) begin
      en_n    = bus_wdata[C_EN];
      mst_n   = bus_wdata[C_MST];
      cpol_n  = bus_wdata[C_CPOL];
      cpha_n  = bus_wdata[C_CPHA];
      gap_n   = bus_wdata[C_GAP];
      cspol_n = bus_wdata[C_CSPOL];
      bits_n  = bus_wdata[C_BITS_LSB +: BC_W];
      rate_n  = bus_wdata[C_RATE_LSB +: RATE_W];
      csidx_n = bus_wdata[C_CSIDX_LSB +: CSI_W];
      if (bus_wdata[C_XCH]) xch_n = 1'b1;
    end
    if (wr_ien) begin
      ie_txe_n = bus_wdata[IE_TXE];
      ie_rxr_n = bus_wdata[IE_RXR];
    end
    if (rx_push && rx_full) ovf_n = 1'b1;
    if (srst) begin
      en_n     = 1'b0;
      mst_n    = 1'b0;
      xch_n    = 1'b0;
      cpol_n   = 1'b0;
      cpha_n   = 1'b0;
      gap_n    = 1'b0;
      cspol_n  = 1'b0;
      bits_n   = '0;
      rate_n   = '0;
      csidx_n  = '0;
      ie_txe_n = 1'b0;
      ie_rxr_n = 1'b0;
      ovf_n    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      en_q     <= 1'b0;
      mst_q    <= 1'b0;
      xch_q    <= 1'b0;
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
      gap_q    <= 1'b0;
      cspol_q  <= 1'b0;
      bits_q   <= '0;
      rate_q   <= '0;
      csidx_q  <= '0;
      ie_txe_q <= 1'b0;
      ie_rxr_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      en_q     <= en_n;
      mst_q    <= mst_n;
      xch_q    <= xch_n;
      cpol_q   <= cpol_n;
      cpha_q   <= cpha_n;
      gap_q    <= gap_n;
      cspol_q  <= cspol_n;
      bits_q   <= bits_n;
      rate_q   <= rate_n;
      csidx_q  <= csidx_n;
      ie_txe_q <= ie_txe_n;
      ie_rxr_q <= ie_rxr_n;
      ovf_q    <= ovf_n;
    end
  end

  spim_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk  (clk),
    .rst_n(rst_n_s),
    .clr  (srst),
    .push (wr_txd),
    .din  (bus_wdata[DATA_W-1:0]),
    .pop  (tx_pop),
    .dout (tx_head),
    .empty(tx_empty),
    .full (tx_full)
  );

  spim_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk  (clk),
    .rst_n(rst_n_s),
    .clr  (srst),
    .push (rx_push),
    .din  (rx_word),
    .pop  (rd_rxd),
    .dout (rx_head),
    .empty(rx_empty),
    .full (rx_full)
  );

  spim_engine #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clr     (srst),
    .go      (go),
    .tx_avail(!tx_empty),
    .tx_word (tx_head),
    .bits_m1 (bits_q),
    .cpol    (cpol_q),
    .cpha    (cpha_q),
    .gap     (gap_q),
    .rate    (rate_q),
    .miso    (spi_miso),
    .tx_pop  (tx_pop),
    .rx_push (rx_push),
    .rx_word (rx_word),
    .mosi    (spi_mosi),
    .sclk    (spi_sclk),
    .cs_act  (cs_act),
    .busy    (busy)
  );

  // chip-select fan-out, one line per target
  for (genvar g = 0; g < CS_LINES; g++) begin : g_cs
    assign spi_cs[g] = (cs_act && (csidx_q == CSI_W'(g))) ? cspol_q : ~cspol_q;
  end

  // read mux
  logic [31:0] ctl_rd, sta_rd;
  always_comb begin
    ctl_rd                          = '0;
    ctl_rd[C_EN]                    = en_q;
    ctl_rd[C_MST]                   = mst_q;
    ctl_rd[C_XCH]                   = xch_q;
    ctl_rd[C_CPOL]                  = cpol_q;
    ctl_rd[C_CPHA]                  = cpha_q;
    ctl_rd[C_GAP]                   = gap_q;
    ctl_rd[C_CSPOL]                 = cspol_q;
    ctl_rd[C_BITS_LSB +: BC_W]      = bits_q;
    ctl_rd[C_RATE_LSB +: RATE_W]    = rate_q;
    ctl_rd[C_CSIDX_LSB +: CSI_W]    = csidx_q;
    sta_rd                          = '0;
    sta_rd[ST_TXE]                  = tx_empty;
    sta_rd[ST_RXR]                  = !rx_empty;
    sta_rd[ST_OVF]                  = ovf_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      unique case (bus_addr)
        OFF_RXD: bus_rdata = rx_empty ? '0 : 32'(rx_head);
        OFF_CTL: bus_rdata = ctl_rd;
        OFF_IEN: begin
          bus_rdata[IE_TXE] = ie_txe_q;
          bus_rdata[IE_RXR] = ie_rxr_q;
        end
        OFF_STA: bus_rdata = sta_rd;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq = (ie_txe_q && tx_empty) || (ie_rxr_q && !rx_empty);

  logic unused_sink;
  assign unused_sink = ^{bus_wdata, tx_full};

  // R6: the exchange bit only drops once the queue is drained, or by soft reset
  p_xch_drain_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(xch_q) |-> ($past(srst) || $past(tx_empty)));
  // R9: overflow flag holds until the soft reset
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ovf_q && !srst) |=> ovf_q);
  // R10: no request while both enables are clear
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ie_txe_q && !ie_rxr_q) |-> !irq);
  // R6: no serial activity while the core is disabled
  p_no_run_off_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!en_q && !busy) |=> !busy);
endmodule

// File: tb/tb_spim_ctrl.sv
module tb_spim_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq, spi_sclk, spi_mosi, spi_miso;
  logic [3:0]  spi_cs;
  logic        inv_r;

  always #5 clk = ~clk;

  spim_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs(spi_cs)
  );

  assign spi_miso = spi_mosi ^ inv_r;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // serial observer: acts as the target, independent of the design
  logic        mon_cpol = 0, mon_cpha = 0, mon_cspol = 0, mon_clr = 0;
  logic [31:0] cap;
  int          edges, ival, last_cyc, cs_starts;
  logic [3:0]  cs_pat;
  logic        prev_sclk = 0, prev_on = 0, on, lead;
  always @(negedge clk) begin
    on = mon_cspol ? (|spi_cs) : !(&spi_cs);
    if (mon_clr) begin
      cap = 0; edges = 0; ival = 0; cs_starts = 0; cs_pat = 4'h0; last_cyc = cyc;
    end else begin
      if (on && !prev_on) begin
        cs_starts++;
        cs_pat = spi_cs;
      end
      if ((spi_sclk !== prev_sclk) && on) begin
        lead = (spi_sclk != mon_cpol);
        if (lead ^ mon_cpha) cap = {cap[30:0], spi_mosi};
        edges++;
        if (edges == 2) ival = cyc - last_cyc;
        last_cyc = cyc;
      end
    end
    prev_sclk = spi_sclk;
    prev_on   = on;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic mon_reset();
    mon_clr = 1;
    @(negedge clk);
    @(negedge clk);
    mon_clr = 0;
  endtask

  task automatic wait_done();
    logic [31:0] c;
    for (int n = 0; n < 5000; n++) begin
      rd(5'h08, c);
      if (!c[2]) break;
    end
  endtask

  localparam logic [31:0] EN_MST = 32'h3;
  localparam logic [31:0] XCH    = 32'h4;

  // {cpol, cpha, bits-1, rate, cs index, cs active-high, invert input, pad, tx, expected rx}
  localparam logic [79:0] VEC [6] = '{
    {1'b0, 1'b0, 5'd7,  3'd0, 2'd0, 1'b0, 1'b0, 2'b00, 32'h000000A5, 32'h000000A5},
    {1'b1, 1'b0, 5'd15, 3'd1, 2'd1, 1'b1, 1'b1, 2'b00, 32'h00001234, 32'h0000EDCB},
    {1'b0, 1'b1, 5'd31, 3'd0, 2'd2, 1'b0, 1'b0, 2'b00, 32'hDEADBEEF, 32'hDEADBEEF},
    {1'b1, 1'b1, 5'd0,  3'd0, 2'd3, 1'b0, 1'b0, 2'b00, 32'h00000003, 32'h00000001},
    {1'b0, 1'b0, 5'd11, 3'd2, 2'd0, 1'b1, 1'b0, 2'b00, 32'hFFFFF0F3, 32'h000000F3},
    {1'b1, 1'b1, 5'd4,  3'd3, 2'd1, 1'b0, 1'b1, 2'b00, 32'h00000015, 32'h0000000A}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog expired act=%0d exp=%0d", cyc, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, ctl, mask;
    bus_en = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; inv_r = 0;
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // reset state
    rd(5'h08, d); chk(d == 0, "R1 ctl after reset", d, 0);
    rd(5'h14, d); chk(d == 32'h1, "R1 status after reset", d, 32'h1);
    chk(spi_cs == 4'hF, "R1 cs idle after reset", 32'(spi_cs), 32'hF);
    chk(spi_sclk == 1'b0, "R1 sclk idle after reset", 32'(spi_sclk), 0);
    chk(irq == 1'b0, "R10 irq after reset", 32'(irq), 0);

    // table of single-word transfers over modes, widths and rates
    for (int v = 0; v < 6; v++) begin
      logic [79:0] e;
      logic [4:0]  bm1;
      logic [2:0]  rate;
      logic [1:0]  idx;
      logic [3:0]  cs_exp;
      e = VEC[v];
      bm1 = e[77:73]; rate = e[72:70]; idx = e[69:68];
      mon_cpol = e[79]; mon_cpha = e[78]; mon_cspol = e[67]; inv_r = e[66];
      ctl = EN_MST | (32'(e[79]) << 4) | (32'(e[78]) << 5) | (32'(e[67]) << 7)
          | (32'(bm1) << 8) | (32'(rate) << 16) | (32'(idx) << 24);
      wr(5'h08, ctl);
      mon_reset();
      wr(5'h04, e[63:32]);
      wr(5'h08, ctl | XCH);
      wait_done();
      mask = (bm1 == 5'd31) ? 32'hFFFFFFFF : ((32'd1 << (bm1 + 1)) - 1);
      cs_exp = e[67] ? (4'b1 << idx) : ~(4'b1 << idx);
      rd(5'h14, d); chk(d[3] == 1'b1, "R3 rx ready after word", d, 32'h9);
      rd(5'h00, d); chk(d == e[31:0], "R3 R4 received word", d, e[31:0]);
      chk(cap == (e[63:32] & mask), "R2 msb-first bits on line", cap, e[63:32] & mask);
      chk(edges == 2 * (int'(bm1) + 1), "R2 clock edge count", edges, 2 * (int'(bm1) + 1));
      chk(ival == (2 << rate), "R5 half period", ival, 2 << rate);
      chk(spi_sclk == e[79], "R4 sclk rests at polarity", 32'(spi_sclk), 32'(e[79]));
      chk(cs_pat == cs_exp, "R7 selected cs line and level", 32'(cs_pat), 32'(cs_exp));
      chk(spi_cs == (e[67] ? 4'h0 : 4'hF), "R7 cs released after word", 32'(spi_cs), e[67] ? 0 : 32'hF);
      rd(5'h08, d); chk(d[2] == 1'b0, "R6 exchange bit self-clears", d, ctl);
    end
    inv_r = 0; mon_cpol = 0; mon_cpha = 0; mon_cspol = 0;

    // burst of nine writes: eight queued, one dropped, one chip select
    ctl = EN_MST | (32'd7 << 8);
    wr(5'h08, ctl);
    mon_reset();
    for (int i = 0; i < 9; i++) wr(5'h04, 32'h10 + 3 * i);
    wr(5'h08, ctl | XCH);
    wait_done();
    chk(cs_starts == 1, "R7 cs held for whole burst", cs_starts, 1);
    chk(edges == 128, "R6 burst sends all queued words", edges, 128);
    rd(5'h14, d); chk(d == 32'h9, "R8 status after full burst", d, 32'h9);
    for (int i = 0; i < 8; i++) begin
      rd(5'h00, d); chk(d == 32'h10 + 3 * i, "R8 word order through both FIFOs", d, 32'h10 + 3 * i);
    end
    rd(5'h14, d); chk(d == 32'h1, "R3 rx empty after draining, ninth dropped", d, 32'h1);

    // receive overflow
    for (int i = 0; i < 8; i++) wr(5'h04, 32'h40 + i);
    wr(5'h08, ctl | XCH);
    wait_done();
    wr(5'h04, 32'h77);
    wr(5'h08, ctl | XCH);
    wait_done();
    rd(5'h14, d); chk(d == 32'h89, "R9 overflow flagged", d, 32'h89);
    rd(5'h00, d); chk(d == 32'h40, "R9 oldest word kept", d, 32'h40);
    for (int i = 1; i < 8; i++) rd(5'h00, d);
    chk(d == 32'h47, "R9 last stored word, extra dropped", d, 32'h47);
    rd(5'h14, d); chk(d == 32'h81, "R9 overflow sticky after drain", d, 32'h81);
    wr(5'h1C, 32'h1);
    rd(5'h14, d); chk(d == 32'h1, "R1 status after soft reset", d, 32'h1);
    rd(5'h08, d); chk(d == 0, "R1 ctl after soft reset", d, 0);

    // chip select released between words
    ctl = EN_MST | (32'd7 << 8) | (32'd1 << 6);
    wr(5'h08, ctl);
    mon_reset();
    for (int i = 0; i < 3; i++) wr(5'h04, 32'hC0 + i);
    wr(5'h08, ctl | XCH);
    wait_done();
    chk(cs_starts == 3, "R7 cs per word with gap bit", cs_starts, 3);
    for (int i = 0; i < 3; i++) begin
      rd(5'h00, d); chk(d == 32'hC0 + i, "R7 data intact with gaps", d, 32'hC0 + i);
    end

    // interrupt
    chk(irq == 1'b0, "R10 irq quiet with enables clear", 32'(irq), 0);
    wr(5'h0C, 32'h1);
    chk(irq == 1'b1, "R10 tx-empty request", 32'(irq), 1);
    wr(5'h0C, 32'h8);
    chk(irq == 1'b0, "R10 rx-ready masked while empty", 32'(irq), 0);
    ctl = EN_MST | (32'd7 << 8);
    wr(5'h08, ctl);
    wr(5'h04, 32'h3C);
    wr(5'h08, ctl | XCH);
    wait_done();
    chk(irq == 1'b1, "R10 rx-ready request", 32'(irq), 1);
    rd(5'h00, d);
    chk(irq == 1'b0, "R10 request drops after read", 32'(irq), 0);
    wr(5'h0C, 32'h0);

    // exchange held off while disabled
    ctl = 32'h2 | (32'd7 << 8);
    wr(5'h08, ctl);
    wr(5'h04, 32'h5A);
    mon_reset();
    wr(5'h08, ctl | XCH);
    repeat (200) @(negedge clk);
    chk(edges == 0, "R6 no clock while disabled", edges, 0);
    rd(5'h08, d); chk(d[2] == 1'b1, "R6 exchange bit pending", d, ctl | XCH);
    rd(5'h14, d); chk(d == 32'h0, "R6 word still queued", d, 0);
    wr(5'h08, ctl | 32'h1 | XCH);
    wait_done();
    rd(5'h00, d); chk(d == 32'h5A, "R6 word sent once enabled", d, 32'h5A);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule